// File: doc/BRIEF.md
# Block Depth-Merge Engine

This engine sits between the pixel caches of several rasterizers and a single shared frame buffer. Each rasterizer evicts whole cache blocks into a first-in first-out queue, one bus beat at a time. The engine takes the oldest block and issues one read request for the matching frame-buffer block. It then accepts the block's beats from memory and pairs each one with the matching queued beat. A pool of per-pixel compare units keeps, for every pixel, whichever of the two fragments is nearer. After a fixed bus turnaround gap the engine writes the merged block back as one burst.

Because the compare happens at eviction time against the stored value, two rasterizers that touch the same screen block in any order leave the nearer fragment in memory. The rasterizers never need to keep their caches coherent with each other.

A bus beat is `2*LANES*ZW` bits wide. With the defaults that is 256 bits: four 32-bit depth words in the low half and four 32-bit color words in the high half. A block is `BEATS` beats long. The turnaround gap lasts `GAP` cycles.

Top module: `zm_merge_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `rd_req` and `wr_valid` are 0 and `in_ready` is 1.
- R2: `rd_req` is a single-cycle pulse carrying the address of the queue-head block in `rd_addr`. It is raised only once at least `BEATS` beats are queued. With fewer beats queued the engine stays idle.
- R3: For pixel lane i, the depth sits in bits [ZW*i +: ZW] and the color in bits [LANES*ZW + ZW*i +: ZW]. When the queued depth is strictly less than the stored depth (unsigned), both the queued depth and the queued color are written for that lane.
- R4: When the queued depth is equal to or greater than the stored depth, the stored depth and color are written back unchanged for that lane. An all-ones depth therefore never replaces anything.
- R5: Each lane is decided on its own depth pair only, so one beat can carry a mix of replaced and kept lanes.
- R6: After the cycle in which the last read beat is accepted, `wr_valid` stays low for exactly `GAP` cycles. It then rises with `wr_beat` equal to 0.
- R7: Write beats leave in order 0 to `BEATS`-1 with `wr_addr` equal to the block address. While `wr_ready` is low, `wr_valid`, `wr_data`, `wr_beat` and `wr_addr` hold.
- R8: Blocks are merged strictly in the order in which they entered the queue.
- R9: `busy` is high from the `rd_req` cycle until the last write beat is accepted. It is low in the cycle after that acceptance.
- R10: `in_ready` is low while the queue holds `QDEPTH` beats. A beat offered then is dropped and disturbs no queued block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Evicted beat offered to the queue |
| in_ready | output | 1 | Queue can accept a beat |
| in_addr | input | AW | Frame-buffer block address of the beat |
| in_data | input | 2*LANES*ZW | Evicted beat: depths low, colors high |
| rd_req | output | 1 | One-cycle read request for a whole block |
| rd_addr | output | AW | Block address of the read request |
| rd_valid | input | 1 | Read beat from memory is present |
| rd_data | input | 2*LANES*ZW | Stored beat, same layout as `in_data` |
| wr_valid | output | 1 | Merged write beat is present |
| wr_ready | input | 1 | Memory accepts the write beat |
| wr_addr | output | AW | Block address of the write burst |
| wr_beat | output | max(1,clog2(BEATS)) | Beat index within the block |
| wr_data | output | 2*LANES*ZW | Merged beat |
| busy | output | 1 | A block is being read, held or written |

## Verification
The bench targets the equality case of the depth compare. A design using less-or-equal would overwrite a stored pixel with an equally distant fragment and change the color. It drives all-ones and zero depths to catch signed compares. It also mixes lanes within one beat, which catches swapped lane or half positions.

It counts the quiet cycles between the read and write bursts, which exposes an off-by-one gap counter. It also stalls writes to check that beats hold and are not skipped. It revisits an address whose stored value was already updated, which shows whether merges really use the fresh read data.

Finally, it fills the queue while memory stalls and offers an extra beat. A design that accepted that beat would overwrite the oldest queued beat, or would start a phantom block after draining.

// File: rtl/zm_pkg.sv
package zm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_READ,
    ST_GAP,
    ST_WRITE
  } zm_state_e;

  function automatic int unsigned zm_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/zm_queue.sv
module zm_queue #(
  parameter int DEPTH = 128,
  parameter int W     = 272
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int PW = zm_pkg::zm_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  assign full      = (count == CW'(DEPTH));
  assign head_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push && !full) wp <= (wp == PLAST) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == PLAST) ? '0 : rp + 1'b1;
      case ({push && !full, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/zm_lane_alu.sv
module zm_lane_alu #(
  parameter int ZW = 32
) (
  input  logic [ZW-1:0] new_z,
  input  logic [ZW-1:0] new_c,
  input  logic [ZW-1:0] old_z,
  input  logic [ZW-1:0] old_c,
  output logic [ZW-1:0] out_z,
  output logic [ZW-1:0] out_c
);
  logic nearer;

  always_comb begin
    nearer = (new_z < old_z);
    out_z  = nearer ? new_z : old_z;
    out_c  = nearer ? new_c : old_c;
  end
endmodule

// File: rtl/zm_beat_merge.sv
module zm_beat_merge #(
  parameter int LANES = 4,
  parameter int ZW    = 32
) (
  input  logic [2*LANES*ZW-1:0] new_beat,
  input  logic [2*LANES*ZW-1:0] old_beat,
  output logic [2*LANES*ZW-1:0] out_beat
);
  localparam int CBASE = LANES * ZW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    zm_lane_alu #(.ZW(ZW)) u_alu (
      .new_z (new_beat[ZW*i +: ZW]),
      .new_c (new_beat[CBASE + ZW*i +: ZW]),
      .old_z (old_beat[ZW*i +: ZW]),
      .old_c (old_beat[CBASE + ZW*i +: ZW]),
      .out_z (out_beat[ZW*i +: ZW]),
      .out_c (out_beat[CBASE + ZW*i +: ZW])
    );
  end
endmodule

// File: rtl/zm_merge_engine.sv
module zm_merge_engine #(
  parameter int LANES  = 4,
  parameter int ZW     = 32,
  parameter int BEATS  = 4,
  parameter int GAP    = 2,
  parameter int QDEPTH = 128,
  parameter int AW     = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [AW-1:0]                          in_addr,
  input  logic [2*LANES*ZW-1:0]                  in_data,
  output logic                                   rd_req,
  output logic [AW-1:0]                          rd_addr,
  input  logic                                   rd_valid,
  input  logic [2*LANES*ZW-1:0]                  rd_data,
  output logic                                   wr_valid,
  input  logic                                   wr_ready,
  output logic [AW-1:0]                          wr_addr,
  output logic [zm_pkg::zm_bits(BEATS)-1:0]      wr_beat,
  output logic [2*LANES*ZW-1:0]                  wr_data,
  output logic                                   busy
);
  import zm_pkg::*;

  localparam int BUS = 2 * LANES * ZW;
  localparam int QW  = AW + BUS;
  localparam int BW  = zm_bits(BEATS);
  localparam int GW  = zm_bits(GAP);
  localparam int CW  = $clog2(QDEPTH + 1);
  localparam logic [BW-1:0] RLAST = BW'(BEATS - 1);
  localparam logic [GW-1:0] GLAST = GW'((GAP > 0) ? GAP - 1 : 0);

  zm_state_e     state;
  logic [BW-1:0] rcnt, wcnt;
  logic [GW-1:0] gcnt;
  logic [AW-1:0] blk_addr;

  logic [QW-1:0]  q_head;
  logic [CW-1:0]  q_count;
  logic           q_full;
  logic           q_pop;
  logic           start;
  logic [BUS-1:0] merged;
  logic [BUS-1:0] wbuf [BEATS];

  zm_queue #(.DEPTH(QDEPTH), .W(QW)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (in_valid),
    .push_data ({in_addr, in_data}),
    .pop       (q_pop),
    .head_data (q_head),
    .count     (q_count),
    .full      (q_full)
  );

  zm_beat_merge #(.LANES(LANES), .ZW(ZW)) u_merge (
    .new_beat (q_head[BUS-1:0]),
    .old_beat (rd_data),
    .out_beat (merged)
  );

  assign start = (state == ST_IDLE) && (q_count >= CW'(BEATS));
  assign q_pop = (state == ST_READ) && rd_valid;

  always_ff @(posedge clk) begin
    if (q_pop) wbuf[rcnt] <= merged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rcnt     <= '0;
      wcnt     <= '0;
      gcnt     <= '0;
      blk_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_REQ;
          blk_addr <= q_head[QW-1:BUS];
          rcnt     <= '0;
        end
        ST_REQ: state <= ST_READ;
        ST_READ: if (rd_valid) begin
          if (rcnt == RLAST) begin
            rcnt  <= '0;
            gcnt  <= '0;
            wcnt  <= '0;
            state <= (GAP == 0) ? ST_WRITE : ST_GAP;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gcnt == GLAST) state <= ST_WRITE;
          else gcnt <= gcnt + 1'b1;
        end
        ST_WRITE: if (wr_ready) begin
          if (wcnt == RLAST) state <= ST_IDLE;
          else wcnt <= wcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready = !q_full;
  assign rd_req   = (state == ST_REQ);
  assign rd_addr  = blk_addr;
  assign wr_valid = (state == ST_WRITE);
  assign wr_addr  = blk_addr;
  assign wr_beat  = wcnt;
  assign wr_data  = wbuf[wcnt];
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/zm_merge_chk.sv
module zm_merge_chk #(
  parameter int BEATS = 4,
  parameter int BW    = 2,
  parameter int BUS   = 256,
  parameter int AW    = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_req,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [BW-1:0]  wr_beat,
  input logic [BUS-1:0] wr_data,
  input logic [AW-1:0]  wr_addr,
  input logic           busy
);
  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R9
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req || wr_valid) |-> busy);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_beat == BW'(BEATS - 1)) |=> !busy);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_data) && $stable(wr_beat) && $stable(wr_addr)));

  // R6
  wr_first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> (wr_beat == '0));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !wr_valid);
endmodule

bind zm_merge_engine zm_merge_chk #(
  .BEATS (BEATS),
  .BW    (BW),
  .BUS   (BUS),
  .AW    (AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_req   (rd_req),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_beat  (wr_beat),
  .wr_data  (wr_data),
  .wr_addr  (wr_addr),
  .busy     (busy)
);

// File: tb/zm_merge_engine_test.sv
module zm_merge_engine_test;
  localparam int LANES  = 4;
  localparam int ZW     = 32;
  localparam int BEATS  = 2;
  localparam int GAP    = 3;
  localparam int QDEPTH = 8;
  localparam int AW     = 8;
  localparam int BUS    = 2 * LANES * ZW;
  localparam int BW     = 1;
  localparam int NV     = 6;

  // per-vector block address and lane depths {lane3,lane2,lane1,lane0}
  localparam logic [7:0] VA [NV] = '{8'd1, 8'd2, 8'd1, 8'd7, 8'd3, 8'd7};
  localparam logic [127:0] VZ [NV] = '{
    {32'h0000_0000, 32'h0000_8001, 32'h0000_8000, 32'h0000_7FFF},
    {32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE},
    {32'h0000_8000, 32'h0000_0010, 32'h0000_7FFF, 32'h0000_7FFE},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h0000_0001, 32'h0000_9000, 32'h0000_0001, 32'h0000_9000},
    {32'h0000_0003, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [AW-1:0]  in_addr = '0;
  logic [BUS-1:0] in_data = '0;
  logic           rd_req;
  logic [AW-1:0]  rd_addr;
  logic           rd_valid = 1'b0;
  logic [BUS-1:0] rd_data = '0;
  logic           wr_valid;
  logic           wr_ready = 1'b0;
  logic [AW-1:0]  wr_addr;
  logic [BW-1:0]  wr_beat;
  logic [BUS-1:0] wr_data;
  logic           busy;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [BUS-1:0] fb [16][BEATS];

  always #10 clk = ~clk;

  zm_merge_engine #(
    .LANES(LANES), .ZW(ZW), .BEATS(BEATS), .GAP(GAP), .QDEPTH(QDEPTH), .AW(AW)
  ) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_beat(wr_beat),
    .wr_data(wr_data), .busy(busy)
  );

  task automatic check(input bit ok, input string req,
                       input logic [BUS-1:0] act, input logic [BUS-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [BUS-1:0] mk(input int v, input logic [7:0] a, input int b);
    logic [BUS-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[ZW*i +: ZW]         = VZ[v][ZW*i +: ZW] + 32'(b);
      r[128 + ZW*i +: ZW]   = {8'hC0, a, 8'(v), 4'(b), 4'(i)};
    end
    return r;
  endfunction

  // expected merge from R3/R4/R5: nearer (strictly smaller) depth wins per lane
  function automatic logic [BUS-1:0] expect_merge(input logic [BUS-1:0] nb,
                                                  input logic [BUS-1:0] ob);
    logic [BUS-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      if (nb[ZW*i +: ZW] < ob[ZW*i +: ZW]) begin
        r[ZW*i +: ZW]       = nb[ZW*i +: ZW];
        r[128 + ZW*i +: ZW] = nb[128 + ZW*i +: ZW];
      end else begin
        r[ZW*i +: ZW]       = ob[ZW*i +: ZW];
        r[128 + ZW*i +: ZW] = ob[128 + ZW*i +: ZW];
      end
    end
    return r;
  endfunction

  task automatic push_beat(input logic [7:0] a, input logic [BUS-1:0] d);
    in_valid = 1'b1;
    in_addr  = a;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic serve_block(input logic [7:0] a, input int v,
                             input bit stall, input bit req_done);
    logic [BUS-1:0] exp [BEATS];
    int wait_n;
    for (int b = 0; b < BEATS; b++) exp[b] = expect_merge(mk(v, a, b), fb[a][b]);
    if (!req_done) begin
      wait_n = 0;
      while (!rd_req && wait_n < 40) begin
        @(negedge clk);
        wait_n++;
      end
      check(rd_req, "R2 read request", BUS'(rd_req), BUS'(1));
      check(rd_addr == a, "R8 R2 block order address", BUS'(rd_addr), BUS'(a));
      check(busy, "R9 busy at request", BUS'(busy), BUS'(1));
      @(negedge clk);
    end
    for (int b = 0; b < BEATS; b++) begin
      rd_valid = 1'b1;
      rd_data  = fb[a][b];
      @(negedge clk);
    end
    rd_valid = 1'b0;
    for (int g = 0; g < GAP; g++) begin
      check(!wr_valid, "R6 quiet turnaround", BUS'(wr_valid), BUS'(0));
      check(busy, "R9 busy in gap", BUS'(busy), BUS'(1));
      @(negedge clk);
    end
    check(wr_valid, "R6 write after gap", BUS'(wr_valid), BUS'(1));
    for (int b = 0; b < BEATS; b++) begin
      if (stall) begin
        wr_ready = 1'b0;
        @(negedge clk);
        check(wr_valid && wr_beat == BW'(b), "R7 hold under stall",
              BUS'(wr_beat), BUS'(b));
      end
      wr_ready = 1'b1;
      check(wr_beat == BW'(b), "R7 beat index", BUS'(wr_beat), BUS'(b));
      check(wr_addr == a, "R7 write address", BUS'(wr_addr), BUS'(a));
      check(wr_data == exp[b], "R3 R4 R5 merged beat", wr_data, exp[b]);
      @(negedge clk);
    end
    wr_ready = 1'b0;
    check(!busy, "R9 busy released", BUS'(busy), BUS'(0));
    for (int b = 0; b < BEATS; b++) fb[a][b] = exp[b];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < BEATS; b++)
        for (int i = 0; i < LANES; i++) begin
          fb[a][b][ZW*i +: ZW]     = 32'h0000_8000;
          fb[a][b][128 + ZW*i +: ZW] = {8'hB0, 8'(a), 8'(b), 8'(i)};
        end

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !rd_req && !wr_valid && in_ready, "R1 during reset",
          BUS'({busy, rd_req, wr_valid, in_ready}), BUS'(4'b0001));
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !rd_req && !wr_valid && in_ready, "R1 after reset",
          BUS'({busy, rd_req, wr_valid, in_ready}), BUS'(4'b0001));

    // vector table: push a block, serve it, compare merged writes
    for (int v = 0; v < NV; v++) begin
      for (int b = 0; b < BEATS; b++) push_beat(VA[v], mk(v, VA[v], b));
      serve_block(VA[v], v, v[0], 1'b0);
    end

    // R2: a partial block does not start the engine
    push_beat(8'd9, mk(4, 8'd9, 0));
    for (int c = 0; c < 5; c++) begin
      check(!rd_req && !busy, "R2 idle with partial block",
            BUS'({rd_req, busy}), BUS'(0));
      @(negedge clk);
    end
    push_beat(8'd9, mk(4, 8'd9, 1));
    serve_block(8'd9, 4, 1'b0, 1'b0);

    // R10 and R8: fill the queue while memory stalls, offer one extra beat
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < BEATS; b++) push_beat(8'(10 + k), mk(k, 8'(10 + k), b));
    check(!in_ready, "R10 full queue", BUS'(in_ready), BUS'(0));
    check(busy, "R9 busy while waiting for read data", BUS'(busy), BUS'(1));
    push_beat(8'd15, {BUS{1'b0}});
    check(!in_ready, "R10 still full", BUS'(in_ready), BUS'(0));
    serve_block(8'd10, 0, 1'b0, 1'b1);
    for (int k = 1; k < 4; k++) serve_block(8'(10 + k), k, 1'b1, 1'b0);
    for (int c = 0; c < 6; c++) begin
      check(!rd_req && !busy && in_ready, "R10 dropped beat left no trace",
            BUS'({rd_req, busy, in_ready}), BUS'(3'b001));
      @(negedge clk);
    end
    finish_run();
  end
endmodule